// File: doc/BRIEF.md
# Memory Bus Width Adapter

This block sits between a core that always issues 32-bit requests and an external memory bus. The memory behind that bus may be physically 8, 16 or 32 bits wide. One accepted request becomes one, two or four external bus cycles, called beats. The address steps by one memory word per beat. On reads, the narrow slices are collected into a 32-bit word. On writes, the 32-bit word is driven out one slice at a time. In both directions the least significant slice goes first. The core sees a single one-clock done pulse with the full 32-bit result.

Instruction fetches use their own strap. It selects 16-bit or 32-bit program memory, whatever the data width setting. A 16-bit fetch reads the low half, then the high half, and returns {high, low}. Every beat is stretched by a programmed wait count, and further by an external ready input. The width, strap and wait inputs are captured when a request is accepted.

Top module: `mem_width_adapter`

## Requirements
- R1: While and right after reset, with no request, `done_o`, `ext_strb_o` and `ext_we_o` are low.
- R2: A data read with `data_width_i` = 2 (32-bit) takes one beat. With 1 (16-bit) it takes two beats, and with 0 (8-bit) it takes four beats. Each beat takes its slice from the low bits of `ext_rdata_i`. `rdata_o` holds the slices packed least significant first.
- R3: The first beat drives `req_addr_i` on `ext_addr_o`, and each following beat drives the previous address plus one.
- R4: On a data write, `ext_we_o` is high in every beat. `ext_wdata_o` carries the current slice of `req_wdata_i` in its low bits and zeros above, least significant slice first. The value is held for the whole beat.
- R5: A fetch (`req_fetch_i` = 1) ignores `data_width_i` and `req_we_i` and never raises `ext_we_o`. With `prog_w16_i` = 1 it takes two 16-bit beats and returns {second, first}. With 0 it takes one 32-bit beat.
- R6: With `ext_rdy_i` high, each beat keeps `ext_strb_o` high for `wait_cnt_i` + 1 clocks.
- R7: A beat ends only once the wait count has elapsed and `ext_rdy_i` is high. While ready is low, the strobe, address and write data are held.
- R8: `done_o` is a one-clock pulse in the clock after the last beat ends. `ext_strb_o` is low while `done_o` is high.
- R9: Width, strap and wait inputs are sampled at acceptance. Changing them during a transaction does not alter its beat count, beat length or data.
- R10: The unused `data_width_i` code 3 behaves as 32-bit.
- R11: A request is accepted only in the idle clock after done. A request held high through done starts its next transaction one clock after the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request valid, accepted when idle |
| req_we_i | input | 1 | Request is a data write |
| req_fetch_i | input | 1 | Request is an instruction fetch |
| req_addr_i | input | 24 | Start word address |
| req_wdata_i | input | 32 | Write word |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 32 | Assembled read word, valid with done_o |
| data_width_i | input | 2 | Data memory width: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| prog_w16_i | input | 1 | Program memory strap: 1 = 16-bit, 0 = 32-bit |
| wait_cnt_i | input | 4 | Programmed wait states per beat |
| ext_rdy_i | input | 1 | External ready |
| ext_strb_o | output | 1 | External cycle active |
| ext_we_o | output | 1 | External write enable |
| ext_addr_o | output | 24 | External address |
| ext_wdata_o | output | 32 | External write data, slice in low bits |
| ext_rdata_i | input | 32 | External read data, slice in low bits |

## Verification
The assertions watch every cycle for the following:
- a done pulse lasts one clock, with the strobe low during it and in the following clock;
- the address rises by exactly one between consecutive beats;
- the address, write data and write enable stay fixed while ready holds a beat;
- write enable is never high without the strobe.

Only the bench scenarios can show the rest:
- that beats come out in the right count and slice order for each width;
- that fetches follow the strap instead of the data width;
- that each beat lasts the larger of the wait count and the ready stall;
- that inputs changed mid-transaction are ignored.

// File: rtl/mwa_pkg.sv
package mwa_pkg;
  typedef enum logic [1:0] {
    WID_8  = 2'd0,
    WID_16 = 2'd1,
    WID_32 = 2'd2
  } wid_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_DONE = 2'd2
  } st_e;
endpackage

// File: rtl/mwa_beat_plan.sv
module mwa_beat_plan
  import mwa_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BEAT_W = 2
) (
  input  logic              fetch_i,
  input  logic [1:0]        dwidth_i,
  input  logic              prog_w16_i,
  output wid_e              wid_o,
  output logic [BEAT_W-1:0] last_o
);
  always_comb begin
    if (fetch_i) begin
      wid_o = prog_w16_i ? WID_16 : WID_32;
    end else begin
      case (dwidth_i)
        2'd0:    wid_o = WID_8;
        2'd1:    wid_o = WID_16;
        default: wid_o = WID_32;  // code 3 treated as full width
      endcase
    end
  end

  always_comb begin
    case (wid_o)
      WID_8:   last_o = BEAT_W'(LANES - 1);
      WID_16:  last_o = BEAT_W'(LANES / 2 - 1);
      default: last_o = '0;
    endcase
  end
endmodule

// File: rtl/mwa_wait_timer.sv
module mwa_wait_timer #(
  parameter int WS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            active_i,
  input  logic [WS_W-1:0] limit_i,
  input  logic            rdy_i,
  output logic            end_o
);
  logic [WS_W-1:0] cnt_q;

  // beat closes only when both the wait count and ready agree
  assign end_o = active_i && (cnt_q >= limit_i) && rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!active_i || end_o) begin
      cnt_q <= '0;
    end else if (cnt_q != '1) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mwa_lane_mux.sv
module mwa_lane_mux
  import mwa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BEAT_W = 2
) (
  input  wid_e              wid_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] ext_rdata_i,
  output logic [DATA_W-1:0] wslice_o,
  output logic [DATA_W-1:0] acc_o
);
  localparam int LANES = DATA_W / 8;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] byte_d;
    always_comb begin
      byte_d = acc_i[8*i +: 8];
      case (wid_i)
        WID_8:   if (beat_i == BEAT_W'(i))     byte_d = ext_rdata_i[7:0];
        WID_16:  if (beat_i == BEAT_W'(i / 2)) byte_d = ext_rdata_i[8*(i%2) +: 8];
        default: byte_d = ext_rdata_i[8*i +: 8];
      endcase
    end
    assign acc_o[8*i +: 8] = byte_d;
  end

  always_comb begin
    wslice_o = '0;
    case (wid_i)
      WID_8:   wslice_o[7:0]  = wdata_i[8*beat_i +: 8];
      WID_16:  wslice_o[15:0] = wdata_i[16*beat_i +: 16];
      default: wslice_o       = wdata_i;
    endcase
  end
endmodule

// File: rtl/mem_width_adapter.sv
module mem_width_adapter
  import mwa_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int WS_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic              req_fetch_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [1:0]        data_width_i,
  input  logic              prog_w16_i,
  input  logic [WS_W-1:0]   wait_cnt_i,
  input  logic              ext_rdy_i,
  output logic              ext_strb_o,
  output logic              ext_we_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [DATA_W-1:0] ext_wdata_o,
  input  logic [DATA_W-1:0] ext_rdata_i
);
  localparam int LANES  = DATA_W / 8;
  localparam int BEAT_W = $clog2(LANES);

  st_e               st_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wd_q;
  wid_e              wid_q;
  logic [WS_W-1:0]   ws_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] last_q;
  logic [DATA_W-1:0] acc_q;

  wid_e              wid_d;
  logic [BEAT_W-1:0] last_d;
  logic              beat_end;
  logic [DATA_W-1:0] acc_next;
  logic [DATA_W-1:0] wslice;
  logic              accept;
  logic              in_bus;

  assign accept = (st_q == ST_IDLE) && req_i;
  assign in_bus = (st_q == ST_BUS);

  mwa_beat_plan #(.LANES(LANES), .BEAT_W(BEAT_W)) u_plan (
    .fetch_i    (req_fetch_i),
    .dwidth_i   (data_width_i),
    .prog_w16_i (prog_w16_i),
    .wid_o      (wid_d),
    .last_o     (last_d)
  );

  mwa_wait_timer #(.WS_W(WS_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (in_bus),
    .limit_i  (ws_q),
    .rdy_i    (ext_rdy_i),
    .end_o    (beat_end)
  );

  mwa_lane_mux #(.DATA_W(DATA_W), .BEAT_W(BEAT_W)) u_lanes (
    .wid_i       (wid_q),
    .beat_i      (beat_q),
    .wdata_i     (wd_q),
    .acc_i       (acc_q),
    .ext_rdata_i (ext_rdata_i),
    .wslice_o    (wslice),
    .acc_o       (acc_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      we_q   <= 1'b0;
      wd_q   <= '0;
      wid_q  <= WID_32;
      ws_q   <= '0;
      beat_q <= '0;
      last_q <= '0;
      acc_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_q   <= ST_BUS;
            addr_q <= req_addr_i;
            we_q   <= req_we_i && !req_fetch_i;
            wd_q   <= req_wdata_i;
            wid_q  <= wid_d;
            ws_q   <= wait_cnt_i;
            beat_q <= '0;
            last_q <= last_d;
            acc_q  <= '0;
          end
        end
        ST_BUS: begin
          if (beat_end) begin
            acc_q <= acc_next;
            if (beat_q == last_q) begin
              st_q <= ST_DONE;
            end else begin
              beat_q <= beat_q + 1'b1;
              addr_q <= addr_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o      = (st_q == ST_DONE);
  assign rdata_o     = acc_q;
  assign ext_strb_o  = in_bus;
  assign ext_we_o    = in_bus && we_q;
  assign ext_addr_o  = addr_q;
  assign ext_wdata_o = (in_bus && we_q) ? wslice : '0;
endmodule

// File: rtl/mwa_checker.sv
module mwa_checker #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic              ext_rdy_i,
  input logic              ext_strb_o,
  input logic              ext_we_o,
  input logic [ADDR_W-1:0] ext_addr_o,
  input logic [DATA_W-1:0] ext_wdata_o
);
  AST_DONE_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_NO_STRB_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ext_strb_o); // R8
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !ext_strb_o); // R11
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_strb_o && $past(ext_strb_o) && (ext_addr_o != $past(ext_addr_o)))
      |-> (ext_addr_o == $past(ext_addr_o) + 1'b1)); // R3
  AST_HOLD_ON_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_strb_o && !ext_rdy_i) |=> (ext_strb_o && $stable(ext_addr_o))); // R7
  AST_WDATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_strb_o && !ext_rdy_i) |=> ($stable(ext_wdata_o) && $stable(ext_we_o))); // R4
  AST_WE_IN_STRB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_we_o |-> ext_strb_o); // R4
endmodule

bind mem_width_adapter mwa_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .done_o      (done_o),
  .ext_rdy_i   (ext_rdy_i),
  .ext_strb_o  (ext_strb_o),
  .ext_we_o    (ext_we_o),
  .ext_addr_o  (ext_addr_o),
  .ext_wdata_o (ext_wdata_o)
);

// File: tb/tb_mem_width_adapter.sv
module tb_mem_width_adapter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, fetch = 1'b0;
  logic [23:0] addr = '0;
  logic [31:0] wdat = '0;
  logic        done;
  logic [31:0] rdata;
  logic [1:0]  dwi = 2'd2;
  logic        pw = 1'b0;
  logic [3:0]  wsi = '0;
  logic        rdy = 1'b1;
  logic        strb, ewe;
  logic [23:0] eaddr;
  logic [31:0] ewdata, erdata;

  int nchk = 0, nerr = 0;
  int sclk = 0, wcnt = 0;
  logic [31:0] wlog [256];

  always #5 clk = ~clk;

  mem_width_adapter dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_we_i(we), .req_fetch_i(fetch),
    .req_addr_i(addr), .req_wdata_i(wdat), .done_o(done), .rdata_o(rdata),
    .data_width_i(dwi), .prog_w16_i(pw), .wait_cnt_i(wsi), .ext_rdy_i(rdy),
    .ext_strb_o(strb), .ext_we_o(ewe), .ext_addr_o(eaddr), .ext_wdata_o(ewdata),
    .ext_rdata_i(erdata)
  );

  function automatic logic [31:0] pat(input logic [7:0] a);
    return {a ^ 8'h5A, a + 8'h21, ~a, a};
  endfunction

  function automatic logic [31:0] mk_wdata(input logic [7:0] a);
    return {a, ~a, a ^ 8'hC3, a + 8'h33};
  endfunction

  function automatic int exp_beats(input logic f, input logic [1:0] dw, input logic p);
    if (f) return p ? 2 : 1;
    if (dw == 2'd0) return 4;
    if (dw == 2'd1) return 2;
    return 1;
  endfunction

  function automatic logic [31:0] exp_read(input int nb, input logic [7:0] a);
    if (nb == 4) return {pat(a + 8'd3) [7:0], pat(a + 8'd2) [7:0], pat(a + 8'd1) [7:0], pat(a) [7:0]};
    if (nb == 2) return {pat(a + 8'd1) [15:0], pat(a) [15:0]};
    return pat(a);
  endfunction

  function automatic logic [31:0] exp_slice(input int nb, input logic [31:0] wd, input int k);
    if (nb == 4) return {24'h0, wd[8*k +: 8]};
    if (nb == 2) return {16'h0, wd[16*k +: 16]};
    return wd;
  endfunction

  assign erdata = pat(eaddr[7:0]);

  always @(posedge clk) begin
    if (strb) sclk <= sclk + 1;
    if (strb && ewe) begin
      wlog[eaddr[7:0]] <= ewdata;
      wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic run_txn(input logic f, input logic w, input logic [1:0] dw, input logic p,
                         input logic [3:0] ws, input logic [7:0] a, input int stall,
                         input bit chg, input int exp_sclk, input string tag);
    int nb, s0, w0, waitn;
    logic [31:0] wd;
    nb = exp_beats(f, dw, p);
    wd = mk_wdata(a);
    @(negedge clk);
    req = 1'b1; we = w; fetch = f; dwi = dw; pw = p; wsi = ws;
    addr = {16'h0, a}; wdat = wd; rdy = (stall == 0);
    s0 = sclk; w0 = wcnt;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    if (chg) begin dwi = 2'd2; wsi = 4'd7; pw = ~p; end
    if (stall > 0) begin
      repeat (stall) @(posedge clk);
      @(negedge clk);
      rdy = 1'b1;
    end
    waitn = 0;
    while (!done && waitn < 300) begin
      @(negedge clk);
      waitn++;
    end
    chk(done, $sformatf("%s R8 done seen", tag), 32'(done), 32'd1);
    chk(!strb, $sformatf("%s R8 strobe low at done", tag), 32'(strb), 32'd0);
    chk(sclk - s0 == exp_sclk, $sformatf("%s R6 R7 strobe clocks", tag), 32'(sclk - s0), 32'(exp_sclk));
    if (f || !w) begin
      chk(rdata == exp_read(nb, a), $sformatf("%s R2 R3 R5 read data", tag), rdata, exp_read(nb, a));
      chk(wcnt == w0, $sformatf("%s R5 no write clocks", tag), 32'(wcnt - w0), 32'd0);
    end else begin
      chk(wcnt - w0 == exp_sclk, $sformatf("%s R4 write clocks", tag), 32'(wcnt - w0), 32'(exp_sclk));
      for (int k = 0; k < nb; k++) begin
        chk(wlog[a + 8'(k)] == exp_slice(nb, wd, k), $sformatf("%s R3 R4 write slice %0d", tag, k),
            wlog[a + 8'(k)], exp_slice(nb, wd, k));
      end
    end
    @(negedge clk);
    chk(!done, $sformatf("%s R8 done one clock", tag), 32'(done), 32'd0);
  endtask

  // {fetch, we, dwidth[1:0], prog_w16, wait[3:0], addr[7:0]}
  localparam logic [16:0] VEC [10] = '{
    {1'b0, 1'b0, 2'd2, 1'b0, 4'd0, 8'd10},   // R2 32-bit read
    {1'b0, 1'b0, 2'd1, 1'b0, 4'd0, 8'd20},   // R2 16-bit read
    {1'b0, 1'b0, 2'd0, 1'b0, 4'd0, 8'd30},   // R2 R3 8-bit read
    {1'b0, 1'b0, 2'd0, 1'b1, 4'd2, 8'd40},   // R6 8-bit read, 2 waits
    {1'b0, 1'b1, 2'd0, 1'b0, 4'd0, 8'd50},   // R4 8-bit write
    {1'b0, 1'b1, 2'd1, 1'b0, 4'd1, 8'd60},   // R4 R6 16-bit write
    {1'b1, 1'b0, 2'd0, 1'b1, 4'd0, 8'd70},   // R5 16-bit fetch
    {1'b1, 1'b1, 2'd0, 1'b0, 4'd0, 8'd80},   // R5 32-bit fetch, we ignored
    {1'b0, 1'b0, 2'd3, 1'b0, 4'd0, 8'd90},   // R10 reserved code
    {1'b0, 1'b1, 2'd2, 1'b0, 4'd3, 8'd100}   // R4 R6 32-bit write, 3 waits
  };

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R8 watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [16:0] v;
    int nb;
    repeat (2) @(negedge clk);
    chk(!done && !strb && !ewe, "R1 outputs in reset", {29'h0, done, strb, ewe}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done && !strb && !ewe, "R1 outputs after reset", {29'h0, done, strb, ewe}, 32'h0);

    for (int i = 0; i < 10; i++) begin
      v = VEC[i];
      nb = exp_beats(v[16], v[14:13], v[12]);
      run_txn(v[16], v[15], v[14:13], v[12], v[11:8], v[7:0], 0, 1'b0,
              nb * (int'(v[11:8]) + 1), $sformatf("vec%0d", i));
    end

    // ready stalls
    run_txn(1'b0, 1'b0, 2'd1, 1'b0, 4'd0, 8'd120, 3, 1'b0, 5, "R7 stall");
    run_txn(1'b0, 1'b0, 2'd2, 1'b0, 4'd2, 8'd124, 1, 1'b0, 3, "R7 stall under waits");
    run_txn(1'b0, 1'b0, 2'd2, 1'b0, 4'd1, 8'd126, 3, 1'b0, 4, "R7 late ready");
    run_txn(1'b0, 1'b1, 2'd0, 1'b0, 4'd0, 8'd130, 2, 1'b0, 6, "R7 write stall");

    // inputs changed mid-transaction
    run_txn(1'b0, 1'b0, 2'd0, 1'b0, 4'd1, 8'd140, 0, 1'b1, 8, "R9 mid change");
    run_txn(1'b1, 1'b0, 2'd2, 1'b1, 4'd0, 8'd150, 0, 1'b1, 2, "R9 strap change");

    // request held through done
    @(negedge clk);
    req = 1'b1; we = 1'b0; fetch = 1'b0; dwi = 2'd2; wsi = 4'd0; pw = 1'b0;
    addr = 24'd200; rdy = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(strb && eaddr == 24'd200, "R11 first accepted", {7'h0, strb, eaddr}, {8'h1, 24'd200});
    @(negedge clk);
    chk(done && !strb, "R11 done with strobe low", {30'h0, done, strb}, 32'h2);
    chk(rdata == pat(8'd200), "R11 R2 held-request data", rdata, pat(8'd200));
    @(negedge clk);
    chk(!done && !strb, "R11 idle clock after done", {30'h0, done, strb}, 32'h0);
    @(negedge clk);
    chk(strb, "R11 next accepted after idle", 32'(strb), 32'd1);
    req = 1'b0;
    @(negedge clk);
    chk(done, "R11 second done", 32'(done), 32'd1);
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule